// File: doc/BRIEF.md
# Locked Bus Cycle Controller

This block sits between a processor's bus cycle sequencer and the external bus arbiter. It drives an active-low lock output that keeps a group of bus cycles together, so that no other master can take the bus between them. The typical group is the read and the write of a semaphore update. The sequencer reports each new bus cycle with a start strobe. With that strobe it gives a vector of lock causes and a flag that marks the final cycle of the locked group. The block follows each outstanding cycle until the active-low ready input completes it.

The block also answers external HOLD requests. It hands the bus over only at an idle point, and never while lock is active. A HOLD request that arrives during a locked group waits. When address pipelining lets the next cycle's address go out before the last locked cycle has received ready, lock still drops on that ready edge. The pipelined cycle is already on the bus by then, so the hand-over slips by that one extra cycle.

Top module: `locked_bus_ctl`

## Requirements
- R1: When an accepted cycle start carries at least one set cause bit, lock_n is low after that same clock edge.
- R2: lock_n goes high after the edge where rdy_n is sampled low for a locked cycle marked final, provided no other locked cycle is outstanding. Until then it stays low, including the idle gaps between locked cycles. A cycle with no cause bit set never drives lock_n low.
- R3: hlda is never granted while lock is active. This holds even when the bus is idle between two locked cycles.
- R4: When pipe_en is high, a start is accepted while one cycle is still outstanding. Lock set and release happen on the same edges as without pipelining.
- R5: When a pipelined unlocked cycle is outstanding at the moment lock drops, the HOLD grant waits until that cycle's ready.
- R6: Each cause bit raises lock on its own. The bits are: bit 0 explicit lock prefix, bit 1 exchange with memory, bit 2 descriptor update, bit 3 interrupt acknowledge, bit 4 page-table update.
- R7: A pending hold_req is decided at the first edge where lock is inactive, no cycle is outstanding and no start is presented. hlda rises one clock after that decision and stays high until hold_req is sampled low.
- R8: If a new locked group starts on the same edge where the previous one ends, lock_n stays low with no high pulse.
- R9: While rst_n is low, lock_n is high, hlda is low and all outstanding-cycle state is cleared.
- R10: A cycle start is ignored in two cases: while the bus is being granted or is held by the external master, and while pipe_en is low and an earlier cycle is still outstanding and not completing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cyc_start | input | 1 | Strobe: a new bus cycle begins at this edge |
| lock_cause | input | NSRC | Lock causes of the starting cycle (see R6) |
| lock_final | input | 1 | The starting cycle is the last of its locked group |
| rdy_n | input | 1 | Active-low ready; completes the oldest outstanding cycle |
| pipe_en | input | 1 | Address pipelining is in use |
| hold_req | input | 1 | External master requests the bus |
| lock_n | output | 1 | Active-low bus lock |
| hlda | output | 1 | Hold acknowledge to the external master |

## Verification
The assertions check four things on every cycle: lock and hlda are never active together, a rising lock_n always follows a completed cycle, an accepted locked start always leaves lock active, and hlda is only granted after an idle, unlocked edge and held until hold_req drops. Some properties need whole sequences and only the bench scenarios can show them. These are the one-cycle grant delay caused by a pipelined cycle, lock staying low without a gap when groups abut, the effect of each cause bit, and starts that are ignored while the bus is handed off or while pipelining is off.

// File: rtl/lkc_pkg.sv
package lkc_pkg;

  // One outstanding bus cycle as tracked by the controller
  typedef struct packed {
    logic vld;   // slot holds a cycle
    logic lck;   // cycle belongs to a locked group
    logic fin;   // cycle is the final one of its group
  } slot_t;

  // Bus ownership state of the hold arbiter
  typedef enum logic [1:0] {
    ARB_OWN   = 2'd0,
    ARB_GRANT = 2'd1,
    ARB_EXT   = 2'd2
  } arb_st_t;

endpackage

// File: rtl/lkc_cycle_track.sv
module lkc_cycle_track
  import lkc_pkg::*;
#(
  parameter int unsigned DEPTH = 2,
  localparam int unsigned CW = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          own_bus,
  input  logic          cyc_start,
  input  logic          cyc_locked,
  input  logic          cyc_final,
  input  logic          rdy_n,
  input  logic          pipe_en,
  output logic          start_acc,
  output logic          done,
  output logic          head_lck,
  output logic          head_fin,
  output logic          tail_lck,
  output logic          bus_idle
);

  slot_t          q_q  [DEPTH];
  slot_t          q_nx [DEPTH];
  logic [CW-1:0]  cnt_q;
  logic [CW-1:0]  cnt_nx;
  logic [CW-1:0]  cnt_rem;

  // Oldest cycle completes on a low ready sample
  assign done     = q_q[0].vld && !rdy_n;
  assign head_lck = q_q[0].lck;
  assign head_fin = q_q[0].fin;
  assign bus_idle = (cnt_q == '0);

  assign cnt_rem   = cnt_q - CW'(done);
  assign start_acc = cyc_start && own_bus && (cnt_rem < CW'(DEPTH))
                     && (pipe_en || (cnt_rem == '0));
  assign cnt_nx    = cnt_rem + CW'(start_acc);

  // Any locked cycle queued behind the head
  always_comb begin
    tail_lck = 1'b0;
    for (int i = 1; i < DEPTH; i++) begin
      tail_lck = tail_lck | (q_q[i].vld & q_q[i].lck);
    end
  end

  for (genvar gi = 0; gi < DEPTH; gi++) begin : g_slot
    slot_t shifted;
    if (gi + 1 < DEPTH) begin : g_mid
      assign shifted = done ? q_q[gi+1] : q_q[gi];
    end else begin : g_end
      assign shifted = done ? '0 : q_q[gi];
    end

    always_comb begin
      q_nx[gi] = shifted;
      if (start_acc && (cnt_rem == CW'(gi))) begin
        q_nx[gi].vld = 1'b1;
        q_nx[gi].lck = cyc_locked;
        q_nx[gi].fin = cyc_final;
      end
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        q_q[gi] <= '0;
      end else begin
        q_q[gi] <= q_nx[gi];
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_nx;
    end
  end

  // R10
  no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt_q <= CW'(DEPTH));

endmodule

// File: rtl/lkc_lock_ctl.sv
module lkc_lock_ctl (
  input  logic clk,
  input  logic rst_n,
  input  logic set_i,
  input  logic done_i,
  input  logic head_lck,
  input  logic head_fin,
  input  logic tail_lck,
  output logic lock_act
);

  logic act_q;
  logic act_nx;
  logic clr;

  // Group ends on ready of its final cycle unless another locked cycle waits
  assign clr    = done_i && head_lck && head_fin && !tail_lck;
  assign act_nx = set_i | (act_q & ~clr);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      act_q <= 1'b0;
    end else begin
      act_q <= act_nx;
    end
  end

  assign lock_act = act_q;

  // R1
  lock_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    set_i |=> lock_act);

  // R2
  lock_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!lock_act && $past(lock_act)) |-> $past(done_i && head_fin));

  // R8
  lock_abut_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (lock_act && set_i) |=> lock_act);

endmodule

// File: rtl/lkc_hold_arb.sv
module lkc_hold_arb
  import lkc_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic hold_req,
  input  logic lock_act,
  input  logic bus_idle,
  input  logic cyc_start,
  output logic own_bus,
  output logic hlda
);

  arb_st_t st_q;
  arb_st_t st_nx;

  always_comb begin
    st_nx = st_q;
    case (st_q)
      ARB_OWN: begin
        if (hold_req && !lock_act && bus_idle && !cyc_start) begin
          st_nx = ARB_GRANT;
        end
      end
      ARB_GRANT: st_nx = ARB_EXT;
      ARB_EXT: begin
        if (!hold_req) begin
          st_nx = ARB_OWN;
        end
      end
      default: st_nx = ARB_OWN;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= ARB_OWN;
    end else begin
      st_q <= st_nx;
    end
  end

  assign own_bus = (st_q == ARB_OWN);
  assign hlda    = (st_q == ARB_EXT);

  // R3
  grant_when_free_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(st_q == ARB_GRANT) |-> $past(!lock_act && bus_idle));

  // R7
  hlda_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (hlda && hold_req) |=> hlda);

  // R7
  hlda_release_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(hlda) |-> $past(!hold_req));

endmodule

// File: rtl/locked_bus_ctl.sv
module locked_bus_ctl #(
  parameter int unsigned NSRC  = 5,
  parameter int unsigned DEPTH = 2
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            cyc_start,
  input  logic [NSRC-1:0] lock_cause,
  input  logic            lock_final,
  input  logic            rdy_n,
  input  logic            pipe_en,
  input  logic            hold_req,
  output logic            lock_n,
  output logic            hlda
);

  logic cyc_locked;
  logic start_acc;
  logic done;
  logic head_lck;
  logic head_fin;
  logic tail_lck;
  logic bus_idle;
  logic own_bus;
  logic lock_act;

  // Any cause source locks the starting cycle
  assign cyc_locked = |lock_cause;

  lkc_cycle_track #(.DEPTH(DEPTH)) u_track (
    .clk        (clk),
    .rst_n      (rst_n),
    .own_bus    (own_bus),
    .cyc_start  (cyc_start),
    .cyc_locked (cyc_locked),
    .cyc_final  (lock_final),
    .rdy_n      (rdy_n),
    .pipe_en    (pipe_en),
    .start_acc  (start_acc),
    .done       (done),
    .head_lck   (head_lck),
    .head_fin   (head_fin),
    .tail_lck   (tail_lck),
    .bus_idle   (bus_idle)
  );

  lkc_lock_ctl u_lock (
    .clk      (clk),
    .rst_n    (rst_n),
    .set_i    (start_acc && cyc_locked),
    .done_i   (done),
    .head_lck (head_lck),
    .head_fin (head_fin),
    .tail_lck (tail_lck),
    .lock_act (lock_act)
  );

  lkc_hold_arb u_arb (
    .clk       (clk),
    .rst_n     (rst_n),
    .hold_req  (hold_req),
    .lock_act  (lock_act),
    .bus_idle  (bus_idle),
    .cyc_start (cyc_start),
    .own_bus   (own_bus),
    .hlda      (hlda)
  );

  assign lock_n = ~lock_act;

  // R3
  lock_vs_hlda_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(hlda && !lock_n));

endmodule

// File: tb/locked_bus_ctl_test.sv
module locked_bus_ctl_test;

  localparam int NSRC = 5;

  typedef struct {
    logic  ln;
    logic  ha;
    string tag;
  } exp_t;

  logic            clk = 1'b0;
  logic            rst_n;
  logic            cyc_start;
  logic [NSRC-1:0] lock_cause;
  logic            lock_final;
  logic            rdy_n;
  logic            pipe_en;
  logic            hold_req;
  logic            lock_n;
  logic            hlda;

  int   n_cmp = 0;
  int   n_bad = 0;
  bit   finished = 0;
  exp_t exp_q[$];

  localparam logic [NSRC-1:0] C_PFX  = 5'b00001;
  localparam logic [NSRC-1:0] C_XCHG = 5'b00010;
  localparam logic [NSRC-1:0] C_NONE = 5'b00000;

  always #10 clk = ~clk;  // 50 MHz

  locked_bus_ctl #(.NSRC(NSRC), .DEPTH(2)) uut (
    .clk        (clk),
    .rst_n      (rst_n),
    .cyc_start  (cyc_start),
    .lock_cause (lock_cause),
    .lock_final (lock_final),
    .rdy_n      (rdy_n),
    .pipe_en    (pipe_en),
    .hold_req   (hold_req),
    .lock_n     (lock_n),
    .hlda       (hlda)
  );

  // Driver: apply one clock of stimulus and queue the outputs expected after the edge
  task automatic step(input logic st, input logic [NSRC-1:0] cs, input logic fin,
                      input logic rd, input logic pp, input logic hd,
                      input logic eln, input logic eha, input string tag);
    @(negedge clk);
    rst_n      = 1'b1;
    cyc_start  = st;
    lock_cause = cs;
    lock_final = fin;
    rdy_n      = rd;
    pipe_en    = pp;
    hold_req   = hd;
    exp_q.push_back('{eln, eha, tag});
  endtask

  task automatic rst_step(input logic hd, input string tag);
    @(negedge clk);
    rst_n      = 1'b0;
    cyc_start  = 1'b0;
    lock_cause = '0;
    lock_final = 1'b0;
    rdy_n      = 1'b1;
    pipe_en    = 1'b0;
    hold_req   = hd;
    exp_q.push_back('{1'b1, 1'b0, tag});
  endtask

  // Monitor: compare after each rising edge, away from it
  initial begin
    forever begin
      @(posedge clk);
      #5;
      if (exp_q.size() > 0) begin
        exp_t e;
        e = exp_q.pop_front();
        n_cmp++;
        if (lock_n !== e.ln || hlda !== e.ha) begin
          n_bad++;
          $display("FAIL %s: lock_n=%b hlda=%b expected lock_n=%b hlda=%b at %0t",
                   e.tag, lock_n, hlda, e.ln, e.ha, $time);
        end
      end
    end
  end

  initial begin
    #2ms;
    if (!finished) begin
      n_cmp++;
      n_bad++;
      $display("FAIL watchdog: run did not complete, expected completion");
      $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
      $finish;
    end
  end

  initial begin
    rst_n = 1'b0; cyc_start = 1'b0; lock_cause = '0; lock_final = 1'b0;
    rdy_n = 1'b1; pipe_en = 1'b0; hold_req = 1'b0;

    // R9 reset state, with hold requested during reset
    rst_step(1'b1, "R9");
    rst_step(1'b0, "R9");

    // R1 R2: semaphore read/write pair, no pipelining
    step(1, C_XCHG, 0, 1, 0, 0, 0, 0, "R1");
    step(0, C_NONE, 0, 0, 0, 0, 0, 0, "R2");
    step(1, C_XCHG, 1, 1, 0, 0, 0, 0, "R2");
    step(0, C_NONE, 0, 1, 0, 0, 0, 0, "R2");
    step(0, C_NONE, 0, 0, 0, 0, 1, 0, "R2");
    step(0, C_NONE, 0, 1, 0, 0, 1, 0, "R2");

    // R3 R7: hold arrives during a locked pair, waits, then granted
    step(1, C_PFX, 0, 1, 0, 1, 0, 0, "R3");
    step(0, C_NONE, 0, 0, 0, 1, 0, 0, "R3");
    step(0, C_NONE, 0, 1, 0, 1, 0, 0, "R3");
    step(1, C_PFX, 1, 1, 0, 1, 0, 0, "R3");
    step(0, C_NONE, 0, 0, 0, 1, 1, 0, "R3");
    step(0, C_NONE, 0, 1, 0, 1, 1, 0, "R7");
    step(0, C_NONE, 0, 1, 0, 1, 1, 1, "R7");
    // R10: start while handed off is ignored
    step(1, C_PFX, 1, 1, 0, 1, 1, 1, "R10");
    step(0, C_NONE, 0, 1, 0, 0, 1, 0, "R7");
    step(0, C_NONE, 0, 0, 0, 0, 1, 0, "R10");

    // R4 R5: pipelined locked pair followed by an unlocked pipelined cycle
    step(1, C_XCHG, 0, 1, 1, 1, 0, 0, "R4");
    step(1, C_XCHG, 1, 1, 1, 1, 0, 0, "R4");
    step(0, C_NONE, 0, 0, 1, 1, 0, 0, "R4");
    step(1, C_NONE, 0, 1, 1, 1, 0, 0, "R4");
    step(0, C_NONE, 0, 0, 1, 1, 1, 0, "R4");
    step(0, C_NONE, 0, 1, 1, 1, 1, 0, "R5");
    step(0, C_NONE, 0, 0, 1, 1, 1, 0, "R5");
    step(0, C_NONE, 0, 1, 1, 1, 1, 0, "R5");
    step(0, C_NONE, 0, 1, 1, 1, 1, 1, "R5");
    step(0, C_NONE, 0, 1, 0, 0, 1, 0, "R7");

    // R8: next locked group starts on the ending edge
    step(1, C_PFX, 1, 1, 0, 0, 0, 0, "R8");
    step(1, C_XCHG, 1, 0, 0, 0, 0, 0, "R8");
    step(0, C_NONE, 0, 0, 0, 0, 1, 0, "R8");

    // R2 R10: unlocked cycle; locked start while it waits and pipelining is off
    step(1, C_NONE, 0, 1, 0, 0, 1, 0, "R2");
    step(1, C_PFX, 1, 1, 0, 0, 1, 0, "R10");
    step(0, C_NONE, 0, 0, 0, 0, 1, 0, "R10");
    step(0, C_NONE, 0, 1, 0, 0, 1, 0, "R10");

    // R6: each cause bit locks on its own
    for (int i = 0; i < NSRC; i++) begin
      step(1, NSRC'(1 << i), 1, 1, 0, 0, 0, 0, "R6");
      step(0, C_NONE, 0, 0, 0, 0, 1, 0, "R6");
    end

    // R9: reset in the middle of a locked group clears it
    step(1, C_PFX, 0, 1, 0, 0, 0, 0, "R9");
    rst_step(1'b1, "R9");
    step(0, C_NONE, 0, 1, 0, 0, 1, 0, "R9");
    step(0, C_NONE, 0, 0, 0, 0, 1, 0, "R9");

    @(posedge clk);
    #10;
    @(posedge clk);
    #10;
    finished = 1;
    $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule